// File: doc/BRIEF.md
# Radio Interrupt Source Router

This block sits between the event outputs of a sub-GHz packet radio core and the interrupt inputs of a host. Each cycle it takes one-cycle event pulses from the modem and folds them into a 16-bit pending-status word. Ten bit positions carry meaning and six are reserved. Which event lands in the shared error position depends on the packet mode. Events that the current mode cannot produce are dropped before they reach the status word.

A pending source reaches an interrupt line only when two conditions hold. Its bit must be set in a global enable word. It must also be set in that line's own mask word. There are three lines, and one source may be routed to any subset of them. Pending bits are sticky until software clears them. Software clears a bit by writing a one to its position through a small register port. The same port loads the enable word and the three mask words. Because the lines are levels, a line stays high until every pending, enabled, mapped source behind it has been cleared.

The register port and the event inputs are plain control pins with no handshake. A write takes effect at the next rising clock edge. A read returns the addressed register combinationally, in the same cycle.

Top module: `radio_irq_router`

## Requirements
- R1: After reset, the status word, the enable word and all three line masks read 0, and `irq_o` is 3'b000.
- R2: Events valid in either mode set their status bits at the next clock edge: `evt_i[0]` (transmit done) sets bit 0, `evt_i[1]` (receive done) sets bit 1, `evt_i[2]` (preamble seen) sets bit 2, and `evt_i[10]` (receive or transmit timeout) sets bit 9.
- R3: Status bit 6 has a different source in each mode. When `lora_mode_i`=0 (FSK mode) it captures `evt_i[6]`, a general receive error. When `lora_mode_i`=1 it captures `evt_i[7]`, a payload CRC error. The event belonging to the other mode is ignored.
- R4: `evt_i[3]` (sync word found) sets bit 3 only in FSK mode. In LoRa mode only: `evt_i[4]` (header ok) sets bit 4, `evt_i[5]` (header bad) sets bit 5, `evt_i[8]` (channel activity scan finished) sets bit 7, and `evt_i[9]` (channel activity found) sets bit 8. In the other mode these events leave the status word unchanged.
- R5: Status bits are sticky. A write to address 0 clears every bit written as one and leaves every other bit alone. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: Bits 15..10 of the status, enable and mask registers always read 0. They are never stored, even when written as ones, and they never drive a line.
- R7: `irq_o[k]` is high exactly when some bit is set in all three of status, enable and the mask of line k. A line whose mask is 0 stays low.
- R8: An event whose enable bit is 0 is still latched in status but drives no line. Writing the enable bit later raises the mapped lines in the cycle after the write.
- R9: Several events in one cycle each set their own status bit. One source mapped in several masks raises all of those lines. A line stays high until the last contributing bit is cleared.
- R10: Register addresses on `addr_i`: 0 is status (write-one-to-clear), 1 is enable, and 2, 3 and 4 are the masks of lines 0, 1 and 2. Addresses 5..7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 11 | One-cycle event pulses from the modem, index meaning per R2-R4 |
| lora_mode_i | input | 1 | Packet mode: 1 LoRa, 0 FSK |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wr_data_i | input | 16 | Write data, or clear mask at address 0 |
| rd_data_o | output | 16 | Read data of the addressed register |
| irq_o | output | 3 | Level interrupt lines |

## Verification
A status bit that is lost or stuck shows up on the read port at address 0 one cycle after the event or clear that should have changed it. Through the routing, the same fault appears on every line that maps that bit, in the same cycle. A wrong mode decode or a wrong bit-6 selection appears in status one edge after the event, so checks that compare status after every cycle catch it at once. A corrupted enable or mask register moves the lines as soon as any pending bit meets it. Random traffic therefore mixes long-lived pending bits with frequent mask changes.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_SRC   = 10;
  localparam int NUM_EVT   = 11;
  localparam int NUM_LINES = 3;
  localparam int ADDR_W    = 3;

  // event input indices
  localparam int EV_TXD   = 0;
  localparam int EV_RXD   = 1;
  localparam int EV_PRE   = 2;
  localparam int EV_SYNC  = 3;
  localparam int EV_HOK   = 4;
  localparam int EV_HBAD  = 5;
  localparam int EV_FERR  = 6;
  localparam int EV_CRC   = 7;
  localparam int EV_SCAN  = 8;
  localparam int EV_HIT   = 9;
  localparam int EV_TMO   = 10;

  // status bit positions (software decodes these)
  localparam int SB_TXD  = 0;
  localparam int SB_RXD  = 1;
  localparam int SB_PRE  = 2;
  localparam int SB_SYNC = 3;
  localparam int SB_HOK  = 4;
  localparam int SB_HBAD = 5;
  localparam int SB_ERR  = 6;
  localparam int SB_SCAN = 7;
  localparam int SB_HIT  = 8;
  localparam int SB_TMO  = 9;

  // register addresses
  localparam int A_STATUS = 0;
  localparam int A_ENABLE = 1;
  localparam int A_LINE0  = 2;
endpackage

// File: rtl/rirq_src_map.sv
module rirq_src_map
  import rirq_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NE = NUM_EVT
) (
  input  logic [NE-1:0] evt_i,
  input  logic          lora_i,
  output logic [W-1:0]  set_o
);
  always_comb begin
    set_o          = '0;
    set_o[SB_TXD]  = evt_i[EV_TXD];
    set_o[SB_RXD]  = evt_i[EV_RXD];
    set_o[SB_PRE]  = evt_i[EV_PRE];
    set_o[SB_TMO]  = evt_i[EV_TMO];
    // FSK-only source
    set_o[SB_SYNC] = evt_i[EV_SYNC] & ~lora_i;
    // LoRa-only sources
    set_o[SB_HOK]  = evt_i[EV_HOK]  & lora_i;
    set_o[SB_HBAD] = evt_i[EV_HBAD] & lora_i;
    set_o[SB_SCAN] = evt_i[EV_SCAN] & lora_i;
    set_o[SB_HIT]  = evt_i[EV_HIT]  & lora_i;
    // shared error position
    set_o[SB_ERR]  = lora_i ? evt_i[EV_CRC] : evt_i[EV_FERR];
  end
endmodule

// File: rtl/rirq_status.sv
module rirq_status #(
  parameter int W  = 16,
  parameter int NS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  localparam logic [W-1:0] VALID = {{(W-NS){1'b0}}, {NS{1'b1}}};

  logic [W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= ((status_q & ~clr_i) | set_i) & VALID;
  end

  assign status_o = status_q;

  // R5: uncleared pending bits survive the edge
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

  // R5: a fresh event beats a clear of the same bit
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_i & VALID)) == $past(set_i & VALID)));

  // R6: reserved bits never hold a one
  p_rsvd_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~VALID) == '0);
endmodule

// File: rtl/rirq_cfg.sv
module rirq_cfg #(
  parameter int W  = 16,
  parameter int NS = 10,
  parameter int NL = 3,
  parameter int AW = 3,
  parameter int A_EN = 1,
  parameter int A_L0 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  enable_o,
  output logic [W-1:0]  mask_o [NL]
);
  localparam logic [W-1:0] VALID = {{(W-NS){1'b0}}, {NS{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     enable_o <= '0;
    else if (wr_en_i && addr_i == AW'(A_EN))        enable_o <= wr_data_i & VALID;
  end

  for (genvar k = 0; k < NL; k++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mask_o[k] <= '0;
      else if (wr_en_i && addr_i == AW'(A_L0 + k))  mask_o[k] <= wr_data_i & VALID;
    end

    // R6: reserved mask bits stay clear
    p_rsvd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o[k] & ~VALID) == '0);
  end

  // R6: reserved enable bits stay clear
  p_rsvd_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o & ~VALID) == '0);
endmodule

// File: rtl/rirq_line_route.sv
module rirq_line_route #(
  parameter int W  = 16,
  parameter int NL = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  input  logic [W-1:0] mask_i [NL],
  output logic [NL-1:0] irq_o
);
  logic [W-1:0] armed;
  assign armed = status_i & enable_i;

  for (genvar k = 0; k < NL; k++) begin : g_line
    assign irq_o[k] = |(armed & mask_i[k]);

    // R7: a high line needs a pending, enabled source
    p_line_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[k] |-> (status_i & enable_i) != '0);

    // R7: an empty mask keeps its line low
    p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i[k] == '0) |-> !irq_o[k]);
  end
endmodule

// File: rtl/radio_irq_router.sv
module radio_irq_router
  import rirq_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NS = NUM_SRC,
  parameter int NE = NUM_EVT,
  parameter int NL = NUM_LINES,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_i,
  input  logic          lora_mode_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  output logic [NL-1:0] irq_o
);
  localparam logic [W-1:0] LORA_ONLY =
    W'((1 << SB_HOK) | (1 << SB_HBAD) | (1 << SB_SCAN) | (1 << SB_HIT));
  localparam logic [W-1:0] FSK_ONLY = W'(1 << SB_SYNC);

  logic [W-1:0] set_vec, clr_vec, status, enable;
  logic [W-1:0] mask [NL];
  logic         cfg_wr;

  assign clr_vec = (wr_en_i && addr_i == AW'(A_STATUS)) ? wr_data_i : '0;
  assign cfg_wr  = wr_en_i && addr_i != AW'(A_STATUS);

  rirq_src_map #(.W(W), .NE(NE)) u_map (
    .evt_i (evt_i),
    .lora_i(lora_mode_i),
    .set_o (set_vec)
  );

  rirq_status #(.W(W), .NS(NS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .status_o(status)
  );

  rirq_cfg #(.W(W), .NS(NS), .NL(NL), .AW(AW),
             .A_EN(A_ENABLE), .A_L0(A_LINE0)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .enable_o (enable),
    .mask_o   (mask)
  );

  rirq_line_route #(.W(W), .NL(NL)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_i(status),
    .enable_i(enable),
    .mask_i  (mask),
    .irq_o   (irq_o)
  );

  // R10: read decode
  always_comb begin
    rd_data_o = '0;
    if (addr_i == AW'(A_STATUS))      rd_data_o = status;
    else if (addr_i == AW'(A_ENABLE)) rd_data_o = enable;
    for (int k = 0; k < NL; k++)
      if (addr_i == AW'(A_LINE0 + k)) rd_data_o = mask[k];
  end

  // R4: mode-restricted bits cannot appear from the wrong mode
  p_lora_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lora_mode_i && (status & LORA_ONLY) == '0) |=> (status & LORA_ONLY) == '0);
  p_fsk_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lora_mode_i && (status & FSK_ONLY) == '0) |=> (status & FSK_ONLY) == '0);

  for (genvar k = 0; k < NL; k++) begin : g_chk
    // R9: an enabled, mapped event raises its line one edge later
    p_event_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & enable & mask[k]) != '0 && !cfg_wr) |=> irq_o[k]);
    // R8: enabling a pending mapped source raises the line after the write
    p_late_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == AW'(A_ENABLE) && (status & wr_data_i & mask[k]) != '0)
        |=> irq_o[k]);
  end
endmodule

// File: tb/radio_irq_router_test.sv
`timescale 1ns/1ps
module radio_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic        lora = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] m_st, m_en;
  logic [15:0] m_mk [3];

  always #5 clk = ~clk;

  radio_irq_router uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .lora_mode_i(lora),
    .wr_en_i(we), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] ev2bits(logic [10:0] e, logic lm);
    logic [15:0] b = '0;
    if (e[0])  b |= 16'h0001;
    if (e[1])  b |= 16'h0002;
    if (e[2])  b |= 16'h0004;
    if (e[10]) b |= 16'h0200;
    if (!lm) begin
      if (e[3]) b |= 16'h0008;
      if (e[6]) b |= 16'h0040;
    end else begin
      if (e[4]) b |= 16'h0010;
      if (e[5]) b |= 16'h0020;
      if (e[7]) b |= 16'h0040;
      if (e[8]) b |= 16'h0080;
      if (e[9]) b |= 16'h0100;
    end
    return b;
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_en;
      3'd2: return m_mk[0];
      3'd3: return m_mk[1];
      3'd4: return m_mk[2];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = |(m_st & m_en & m_mk[k]);
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, cross one rising edge, update model, reach next negedge
  task automatic step(logic [10:0] e, logic lm, logic w, logic [2:0] a, logic [15:0] d);
    logic [15:0] clr;
    evt = e; lora = lm; we = w; addr = a; wdata = d;
    @(posedge clk);
    clr = (w && a == 3'd0) ? d : 16'h0;
    m_st = ((m_st & ~clr) | ev2bits(e, lm)) & 16'h03FF;
    if (w && a == 3'd1) m_en = d & 16'h03FF;
    for (int k = 0; k < 3; k++) if (w && a == 3'(2 + k)) m_mk[k] = d & 16'h03FF;
    @(negedge clk);
    evt = '0; we = 1'b0;
  endtask

  task automatic chk_model(string tag);
    check({tag, " read"}, rdata, exp_rd(addr));
    check({tag, " irq"}, {13'h0, irq}, {13'h0, exp_irq()});
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] exp, string tag);
    addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic clear_all();
    step('0, lora, 1'b1, 3'd0, 16'hFFFF);
  endtask

  initial begin
    m_st = '0; m_en = '0;
    for (int k = 0; k < 3; k++) m_mk[k] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 16'h0000, "R1 reset register");
    check("R1 reset lines", {13'h0, irq}, 16'h0000);

    // R2 mode-independent events
    step(11'h001, 1'b0, 1'b0, 3'd0, '0); check("R2 tx done bit0", rdata, 16'h0001);
    clear_all();
    step(11'h400, 1'b1, 1'b0, 3'd0, '0); check("R2 timeout bit9", rdata, 16'h0200);
    clear_all();
    step(11'h006, 1'b1, 1'b0, 3'd0, '0); check("R2 rx+preamble bits1,2", rdata, 16'h0006);
    clear_all();

    // R3 shared error bit
    step(11'h040, 1'b0, 1'b0, 3'd0, '0); check("R3 fsk error", rdata, 16'h0040);
    clear_all();
    step(11'h080, 1'b1, 1'b0, 3'd0, '0); check("R3 lora crc", rdata, 16'h0040);
    clear_all();
    step(11'h080, 1'b0, 1'b0, 3'd0, '0); check("R3 crc ignored in fsk", rdata, 16'h0000);
    step(11'h040, 1'b1, 1'b0, 3'd0, '0); check("R3 fsk error ignored in lora", rdata, 16'h0000);

    // R4 mode-restricted events
    step(11'h330, 1'b0, 1'b0, 3'd0, '0); check("R4 lora-only in fsk", rdata, 16'h0000);
    step(11'h008, 1'b1, 1'b0, 3'd0, '0); check("R4 sync in lora", rdata, 16'h0000);
    step(11'h330, 1'b1, 1'b0, 3'd0, '0); check("R4 lora-only in lora", rdata, 16'h01B0);
    clear_all();
    step(11'h008, 1'b0, 1'b0, 3'd0, '0); check("R4 sync in fsk", rdata, 16'h0008);
    clear_all();

    // R5 sticky, W1C, set wins
    step(11'h001, 1'b0, 1'b0, 3'd0, '0);
    step('0, 1'b0, 1'b0, 3'd0, '0); check("R5 sticky", rdata, 16'h0001);
    step('0, 1'b0, 1'b1, 3'd0, 16'h0002); check("R5 other bit clear", rdata, 16'h0001);
    step(11'h001, 1'b0, 1'b1, 3'd0, 16'h0001); check("R5 set wins", rdata, 16'h0001);
    step('0, 1'b0, 1'b1, 3'd0, 16'h0001); check("R5 clear", rdata, 16'h0000);

    // R6 reserved bits
    step('0, 1'b0, 1'b1, 3'd1, 16'hFFFF); check("R6 enable rsvd", rdata, 16'h03FF);
    step('0, 1'b0, 1'b1, 3'd4, 16'hFC00); check("R6 mask rsvd", rdata, 16'h0000);
    check("R6 rsvd drives nothing", {13'h0, irq}, 16'h0000);

    // R10 unused addresses
    step('0, 1'b0, 1'b1, 3'd6, 16'hFFFF);
    rd(3'd5, 16'h0000, "R10 addr5 reads zero");
    rd(3'd6, 16'h0000, "R10 addr6 reads zero");
    rd(3'd4, 16'h0000, "R10 addr6 write ignored");

    // R8 latched while disabled, late enable
    step('0, 1'b0, 1'b1, 3'd1, 16'h0000);
    step('0, 1'b0, 1'b1, 3'd2, 16'h03FF);
    step(11'h002, 1'b0, 1'b0, 3'd0, '0);
    check("R8 latched while disabled", rdata, 16'h0002);
    check("R8 no line while disabled", {13'h0, irq}, 16'h0000);
    step('0, 1'b0, 1'b1, 3'd1, 16'h0002);
    check("R8 late enable raises line", {13'h0, irq}, 16'h0001);
    clear_all();
    check("R7 line drops after clear", {13'h0, irq}, 16'h0000);

    // R9 multiple sources, fan-out, R7 empty mask
    step('0, 1'b0, 1'b1, 3'd1, 16'h03FF);
    step('0, 1'b0, 1'b1, 3'd2, 16'h0003);
    step('0, 1'b0, 1'b1, 3'd3, 16'h0002);
    step('0, 1'b0, 1'b1, 3'd4, 16'h0000);
    step(11'h003, 1'b0, 1'b0, 3'd0, '0);
    check("R9 both events visible", rdata, 16'h0003);
    check("R9 fan-out lines", {13'h0, irq}, 16'h0003);
    step('0, 1'b0, 1'b1, 3'd0, 16'h0001);
    check("R9 line held by remaining bit", {13'h0, irq}, 16'h0003);
    step('0, 1'b0, 1'b1, 3'd0, 16'h0002);
    check("R9 all cleared", {13'h0, irq}, 16'h0000);
    step(11'h7FF, 1'b1, 1'b0, 3'd0, '0);
    check("R7 zero-mask line low", {13'h0, {1'b0, 2'b00}} | {13'h0, irq[2], 2'b00}, 16'h0000);
    chk_model("R7 directed");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] e;
      logic w;
      logic [2:0] a;
      logic [15:0] d;
      e = 11'($urandom) & 11'($urandom) & 11'($urandom);
      w = ($urandom % 4) == 0;
      a = 3'($urandom % 7);
      d = 16'($urandom);
      if (w && a == 3'd0) d = d & 16'($urandom);
      step(e, 1'($urandom), w, a, d);
      chk_model("R7 R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule